// File: doc/BRIEF.md
# Descriptor-chain DMA engine

A single-channel DMA engine that copies 32-bit words between addresses on a shared memory port. In direct mode it takes source, destination and byte count from its own registers. In chained mode it reads a list of three-word descriptors from memory and runs one transfer per descriptor until a descriptor is flagged as the last. Per-word address stepping comes from a mode register. A source in the external region is always stepped by a word in chained mode.

The engine shares the memory with a CPU. A CPU write still in progress when a start arrives delays the transfer until the write ends. Once words are moving, the CPU is refused the bus until the engine returns to idle. Completion is signalled by a one-cycle interrupt pulse.

Top module: `dmaq_engine`

## Requirements
- R1: In direct mode (mode bit 0 = 0) a start moves ceil(bytes/4) words, each read from the current source address and then written to the current destination address, beginning at the programmed source and destination registers.
- R2: Mode bits [2:1] select the destination step per word: 00 gives 0, 01 gives 2, 10 or 11 gives 4 bytes. Mode bit 3 selects the source step: 1 gives 4 bytes and 0 gives none. The word at address A is the 32-bit word at A[11:2] of the attached memory.
- R3: In chained mode (mode bit 0 = 1) a descriptor is three words at pointer, pointer+4 and pointer+8, holding byte count, destination and source in that order. The next descriptor starts at pointer+12.
- R4: Bit 31 of a descriptor's source word marks the final descriptor. The engine masks that bit out of the address and stops after that descriptor; no later descriptor is fetched or executed.
- R5: A byte count of zero, in either mode, means 2^CNT_W bytes (256 bytes, 64 words, with default parameters).
- R6: If cpuBusReq and cpuBusWrite are both high when a start is accepted, the engine issues no memory request until cpuBusWrite or cpuBusReq falls. Meanwhile the CPU keeps its grant.
- R7: From the first memory request of a run until the engine is idle again, cpuBusGnt stays low. When idle, cpuBusGnt follows cpuBusReq.
- R8: In chained mode a source address whose bits [27:24] equal 4'h2 is stepped by 4 per word even when mode bit 3 is 0. In direct mode such a source obeys mode bit 3.
- R9: Register writes (address 0 mode, 1 source, 2 destination, 3 count, 4 descriptor pointer) made while busy are discarded and set errFlag. errFlag clears when the next start is accepted.
- R10: A start pulse while busy has no effect on the running transfer and starts nothing afterwards.
- R11: doneIrq is high for exactly one cycle per run, in the cycle busy first reads low after the last word has been written. After reset, busy, doneIrq, memReq and errFlag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| start | input | 1 | Start strobe |
| cpuBusReq | input | 1 | CPU requests the shared bus |
| cpuBusWrite | input | 1 | CPU request is a write |
| cpuBusGnt | output | 1 | CPU granted the shared bus |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memGnt | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 32 | Read data, valid the cycle after an accepted read |
| busy | output | 1 | Engine is running or waiting to run |
| doneIrq | output | 1 | Completion pulse |
| errFlag | output | 1 | A register write was discarded while busy |

## Verification
The assertions assume that read data arrives exactly one cycle after an accepted read. The bench memory model always answers that way, and it may refuse requests in any cycle. They also assume the CPU obeys cpuBusGnt and does not change the write qualifier of a request while a start waits. The bench changes cpuBusReq and cpuBusWrite only between runs, or once to release a deferred start. Descriptor lists and transfers are placed so that source and destination never overlap, unless the source step is zero. Under that condition a sequential software model gives a single expected memory image.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  typedef enum logic [1:0] {
    ADR_PTR = 2'd0,
    ADR_SRC = 2'd1,
    ADR_DST = 2'd2
  } adrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    arm;
    logic    capCnt;
    logic    capDst;
    logic    capSrc;
    logic    capData;
    logic    stepWord;
    logic    nextDesc;
    adrSel_e adrSel;
    logic [1:0] fetchIdx;
  } dpCtl_t;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_SRC  = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_PTR  = 3'd4;

endpackage

// File: rtl/dmaq_path.sv
module dmaq_path
  import dmaq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W = 8,
  parameter logic [ADDR_W-1:0] EXT_MASK = 32'h0F00_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              busy,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic              modeIndirect,
  output logic              runIndirect,
  output logic              lastWord,
  output logic              lastDesc,
  output logic              errFlag
);

  localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] WORD_B   = (CNT_W+1)'(4);

  logic [3:0]        modeReg;
  logic [ADDR_W-1:0] srcReg, dstReg, ptrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [ADDR_W-1:0] curSrc, curDst, curPtr, dataBuf;
  logic [CNT_W:0]    remBytes;
  logic [ADDR_W-1:0] srcStep, dstStep;
  logic              extSrc;

  function automatic logic [CNT_W:0] effCount(input logic [CNT_W-1:0] c);
    return (c == '0) ? FULL_CNT : {1'b0, c};
  endfunction

  // programmed registers, frozen while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      srcReg  <= '0;
      dstReg  <= '0;
      cntReg  <= '0;
      ptrReg  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (regWe && !busy) begin
        case (regAddr)
          REG_MODE: modeReg <= regWdata[3:0];
          REG_SRC:  srcReg  <= regWdata;
          REG_DST:  dstReg  <= regWdata;
          REG_CNT:  cntReg  <= regWdata[CNT_W-1:0];
          REG_PTR:  ptrReg  <= regWdata;
          default:  ;
        endcase
      end
      if (ctl.arm) errFlag <= 1'b0;
      else if (regWe && busy) errFlag <= 1'b1;
    end
  end

  assign extSrc  = (curSrc & EXT_MASK) == EXT_BASE;
  assign srcStep = (modeReg[3] || (runIndirect && extSrc)) ? ADDR_W'(4) : '0;

  always_comb begin
    case (modeReg[2:1])
      2'b00:   dstStep = '0;
      2'b01:   dstStep = ADDR_W'(2);
      default: dstStep = ADDR_W'(4);
    endcase
  end

  // working state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc      <= '0;
      curDst      <= '0;
      curPtr      <= '0;
      dataBuf     <= '0;
      remBytes    <= '0;
      runIndirect <= 1'b0;
      lastDesc    <= 1'b0;
    end else begin
      if (ctl.arm) begin
        curSrc      <= srcReg;
        curDst      <= dstReg;
        curPtr      <= ptrReg;
        remBytes    <= effCount(cntReg);
        runIndirect <= modeReg[0];
        lastDesc    <= 1'b0;
      end
      if (ctl.capCnt) remBytes <= effCount(memRdata[CNT_W-1:0]);
      if (ctl.capDst) curDst <= memRdata;
      if (ctl.capSrc) begin
        curSrc   <= {1'b0, memRdata[ADDR_W-2:0]};
        lastDesc <= memRdata[ADDR_W-1];
      end
      if (ctl.capData) dataBuf <= memRdata;
      if (ctl.stepWord) begin
        curSrc   <= curSrc + srcStep;
        curDst   <= curDst + dstStep;
        remBytes <= (remBytes > WORD_B) ? remBytes - WORD_B : '0;
      end
      if (ctl.nextDesc) curPtr <= curPtr + ADDR_W'(12);
    end
  end

  always_comb begin
    case (ctl.adrSel)
      ADR_PTR: memAddr = curPtr + ADDR_W'({ctl.fetchIdx, 2'b00});
      ADR_SRC: memAddr = curSrc;
      default: memAddr = curDst;
    endcase
  end

  assign memWdata     = dataBuf;
  assign modeIndirect = modeReg[0];
  assign lastWord     = remBytes <= WORD_B;

  AST_REG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe) |=> $stable(modeReg)); // R9
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && !ctl.arm) |=> errFlag); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepWord |-> (remBytes != '0)); // R5
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (runIndirect && ctl.adrSel == ADR_SRC && !ctl.arm) |-> !memAddr[ADDR_W-1]); // R4

endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cpuBusReq,
  input  logic   cpuBusWrite,
  input  logic   memGnt,
  input  logic   modeIndirect,
  input  logic   runIndirect,
  input  logic   lastWord,
  input  logic   lastDesc,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   memReq,
  output logic   memWe,
  output logic   cpuBusGnt,
  output logic   doneIrq
);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_FREQ, S_FCAP, S_RREQ, S_RCAP, S_WREQ
  } state_e;

  state_e     state, nxt;
  logic [1:0] idx, idxNxt;
  logic       irqSet;
  logic       cpuWriting;

  assign cpuWriting = cpuBusReq && cpuBusWrite;

  always_comb begin
    nxt        = state;
    idxNxt     = idx;
    ctl        = '0;
    ctl.adrSel = ADR_PTR;
    memReq     = 1'b0;
    memWe      = 1'b0;
    irqSet     = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.arm = 1'b1;
          idxNxt  = '0;
          if (cpuWriting)        nxt = S_HOLD;
          else if (modeIndirect) nxt = S_FREQ;
          else                   nxt = S_RREQ;
        end
      end
      S_HOLD: begin
        if (!cpuWriting) nxt = runIndirect ? S_FREQ : S_RREQ;
      end
      S_FREQ: begin
        memReq       = 1'b1;
        ctl.fetchIdx = idx;
        if (memGnt) nxt = S_FCAP;
      end
      S_FCAP: begin
        ctl.fetchIdx = idx;
        ctl.capCnt   = (idx == 2'd0);
        ctl.capDst   = (idx == 2'd1);
        ctl.capSrc   = (idx == 2'd2);
        if (idx == 2'd2) begin
          idxNxt = '0;
          nxt    = S_RREQ;
        end else begin
          idxNxt = idx + 2'd1;
          nxt    = S_FREQ;
        end
      end
      S_RREQ: begin
        memReq     = 1'b1;
        ctl.adrSel = ADR_SRC;
        if (memGnt) nxt = S_RCAP;
      end
      S_RCAP: begin
        ctl.adrSel  = ADR_SRC;
        ctl.capData = 1'b1;
        nxt         = S_WREQ;
      end
      S_WREQ: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.adrSel = ADR_DST;
        if (memGnt) begin
          ctl.stepWord = 1'b1;
          if (!lastWord) begin
            nxt = S_RREQ;
          end else if (runIndirect && !lastDesc) begin
            ctl.nextDesc = 1'b1;
            nxt          = S_FREQ;
          end else begin
            irqSet = 1'b1;
            nxt    = S_IDLE;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      doneIrq <= 1'b0;
    end else begin
      state   <= nxt;
      idx     <= idxNxt;
      doneIrq <= irqSet;
    end
  end

  assign busy      = (state != S_IDLE);
  assign cpuBusGnt = cpuBusReq && (state == S_IDLE || state == S_HOLD);

  AST_CPU_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuBusGnt); // R7
  AST_START_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWriting && cpuBusGnt) |-> !memReq); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq); // R11
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !irqSet) |=> busy); // R10

endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W = 8,
  parameter logic [ADDR_W-1:0] EXT_MASK = 32'h0F00_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              start,
  input  logic              cpuBusReq,
  input  logic              cpuBusWrite,
  output logic              cpuBusGnt,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              busy,
  output logic              doneIrq,
  output logic              errFlag
);

  dpCtl_t ctl;
  logic   modeIndirect, runIndirect, lastWord, lastDesc;

  dmaq_ctrl uCtrl (
    .clk, .rstN, .start, .cpuBusReq, .cpuBusWrite, .memGnt,
    .modeIndirect, .runIndirect, .lastWord, .lastDesc,
    .ctl, .busy, .memReq, .memWe, .cpuBusGnt, .doneIrq
  );

  dmaq_path #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_MASK(EXT_MASK), .EXT_BASE(EXT_BASE)
  ) uPath (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .busy, .ctl, .memRdata,
    .memAddr, .memWdata, .modeIndirect, .runIndirect, .lastWord, .lastDesc,
    .errFlag
  );

endmodule

// File: tb/tb_dmaq_engine.sv
module tb_dmaq_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        start = 1'b0;
  logic        cpuBusReq = 1'b0;
  logic        cpuBusWrite = 1'b0;
  logic        cpuBusGnt;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memGnt = 1'b1;
  logic [31:0] memRdata = '0;
  logic        busy, doneIrq, errFlag;

  dmaq_engine dut (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .start, .cpuBusReq, .cpuBusWrite,
    .cpuBusGnt, .memReq, .memWe, .memAddr, .memWdata, .memGnt, .memRdata,
    .busy, .doneIrq, .errFlag
  );

  always #5 clk = ~clk;

  logic [31:0] mem    [0:1023];
  logic [31:0] expMem [0:1023];
  int nChecks = 0, nFails = 0;
  int writesSeen = 0, irqSeen = 0, irqWide = 0, reqSeen = 0, heldViol = 0;
  int cycles = 0;
  logic irqPrev = 1'b0;
  logic stallOn = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  // memory model: read data one cycle after an accepted read
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memReq && memGnt) begin
      reqSeen <= reqSeen + 1;
      if (memWe) begin
        mem[memAddr[11:2]] <= memWdata;
        writesSeen <= writesSeen + 1;
      end else begin
        memRdata <= mem[memAddr[11:2]];
      end
    end else if (memReq) begin
      reqSeen <= reqSeen + 1;
    end
    if (doneIrq) irqSeen <= irqSeen + 1;
    if (doneIrq && irqPrev) irqWide <= irqWide + 1;
    irqPrev <= doneIrq;
    if (busy && cpuBusGnt && !(cpuBusReq && cpuBusWrite)) heldViol <= heldViol + 1;
  end

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memGnt <= stallOn ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, "R11 run finishes", busy, 0);
    @(negedge clk);
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 32'h5A00_0000 ^ (i * 32'h0001_0203) ^ seed;
      expMem[i] = mem[i];
    end
  endtask

  function automatic int wordsFor(input int c);
    return ((c == 0 ? 256 : c) + 3) / 4;
  endfunction

  function automatic int dstStepOf(input logic [3:0] m);
    return (m[2:1] == 2'b00) ? 0 : (m[2:1] == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit isExt(input logic [31:0] a);
    return a[27:24] == 4'h2;
  endfunction

  task automatic modelCopy(input logic [31:0] s, d, input int c, input int ss, ds);
    for (int i = 0; i < wordsFor(c); i++) begin
      logic [31:0] sa = s + i * ss;
      logic [31:0] da = d + i * ds;
      expMem[da[11:2]] = expMem[sa[11:2]];
    end
  endtask

  task automatic compareMem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== expMem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (bad != 0)
      check(0, req, mem[first], expMem[first]);
    else
      check(1, req, 0, 0);
  endtask

  task automatic clearCounts();
    writesSeen = 0; irqSeen = 0; reqSeen = 0;
  endtask

  task automatic runDirect(input logic [31:0] s, d, input int c, input logic [3:0] m, input string req);
    fillMem(c * 7 + m);
    modelCopy(s, d, c, m[3] ? 4 : 0, dstStepOf(m));
    regWrite(3'd0, {28'd0, m});
    regWrite(3'd1, s);
    regWrite(3'd2, d);
    regWrite(3'd3, c);
    clearCounts();
    pulseStart();
    waitIdle();
    compareMem(req);
    check(writesSeen == wordsFor(c), req, writesSeen, wordsFor(c));
    check(irqSeen == 1, "R11 one pulse", irqSeen, 1);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    fillMem(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !doneIrq && !memReq && !errFlag, "R11 reset outputs",
          {busy, doneIrq, memReq, errFlag}, 0);
    cpuBusReq = 1'b1;
    @(negedge clk);
    check(cpuBusGnt == 1'b1, "R7 idle grant follows request", cpuBusGnt, 1);
    cpuBusReq = 1'b0;

    // R1 R2 sweep of counts and step combinations in direct mode
    for (int c = 1; c <= 20; c++)
      for (int ss = 0; ss < 2; ss++)
        for (int ds = 0; ds < 3; ds++) begin
          stallOn = c[0];
          runDirect(32'h0000_0100, 32'h0000_0800, c, 4'((ss << 3) | (ds << 1)), "R1/R2 direct copy");
        end
    stallOn = 1'b0;

    // R5 zero count: 64 words
    runDirect(32'h0000_0000, 32'h0000_0800, 0, 4'b1100, "R5 zero count direct");

    // R8 direct mode keeps zero source step for external source
    runDirect(32'h0200_0300, 32'h0000_0800, 12, 4'b0100, "R8 direct ext source no step");

    // R3 R4 R8 chained descriptors, fourth must not run
    fillMem(99);
    stallOn = 1'b1;
    begin
      int base = 32'h200 >> 2;
      mem[base+0] = 32'h20;        mem[base+1] = 32'h800;  mem[base+2] = 32'h100;
      mem[base+3] = 32'h10;        mem[base+4] = 32'h900;  mem[base+5] = 32'h180;
      mem[base+6] = 32'h15;        mem[base+7] = 32'hA00;  mem[base+8] = 32'h8200_0300;
      mem[base+9] = 32'h8;         mem[base+10] = 32'hC00; mem[base+11] = 32'h100;
      for (int i = 0; i < 12; i++) expMem[base+i] = mem[base+i];
    end
    modelCopy(32'h100, 32'h800, 32'h20, 0, 4);
    modelCopy(32'h180, 32'h900, 32'h10, 0, 4);
    modelCopy(32'h0200_0300, 32'hA00, 32'h15, 4, 4);
    regWrite(3'd0, 32'h5);   // chained, dst step 4, src step 0
    regWrite(3'd4, 32'h200);
    clearCounts();
    pulseStart();
    waitIdle();
    compareMem("R3/R4/R8 chained descriptors");
    check(writesSeen == 8 + 4 + 6, "R4 stops after flagged descriptor", writesSeen, 18);
    check(irqSeen == 1, "R11 chain single pulse", irqSeen, 1);
    stallOn = 1'b0;

    // R5 zero count in a descriptor
    fillMem(5);
    mem[32'h200 >> 2] = 32'h0; mem[(32'h200 >> 2) + 1] = 32'h800; mem[(32'h200 >> 2) + 2] = 32'h8000_0000;
    for (int i = 0; i < 3; i++) expMem[(32'h200 >> 2) + i] = mem[(32'h200 >> 2) + i];
    modelCopy(32'h0, 32'h800, 0, 4, 4);
    regWrite(3'd0, 32'hD);
    clearCounts();
    pulseStart();
    waitIdle();
    compareMem("R5 zero count chained");
    check(writesSeen == 64, "R5 zero count word total", writesSeen, 64);

    // R6 deferred start under CPU write
    fillMem(11);
    modelCopy(32'h100, 32'h800, 16, 4, 4);
    regWrite(3'd0, 32'hC);
    regWrite(3'd1, 32'h100);
    regWrite(3'd2, 32'h800);
    regWrite(3'd3, 16);
    cpuBusReq = 1'b1; cpuBusWrite = 1'b1;
    clearCounts();
    pulseStart();
    repeat (8) @(negedge clk);
    check(reqSeen == 0, "R6 no request while CPU writes", reqSeen, 0);
    check(busy && cpuBusGnt, "R6 CPU keeps grant while start waits", {busy, cpuBusGnt}, 2'b11);
    cpuBusReq = 1'b0; cpuBusWrite = 1'b0;
    @(negedge clk);
    waitIdle();
    compareMem("R6 deferred transfer completes");

    // R7 CPU read held off during run
    heldViol = 0;
    cpuBusReq = 1'b1;
    runDirect(32'h100, 32'h800, 24, 4'b1100, "R7 copy with CPU waiting");
    check(heldViol == 0, "R7 no CPU grant while running", heldViol, 0);
    check(cpuBusGnt == 1'b1, "R7 grant returns when idle", cpuBusGnt, 1);
    cpuBusReq = 1'b0;

    // R9 R10 writes and start while busy
    fillMem(21);
    modelCopy(32'h100, 32'h800, 16, 4, 4);
    regWrite(3'd0, 32'hC);
    regWrite(3'd1, 32'h100);
    regWrite(3'd2, 32'h800);
    regWrite(3'd3, 16);
    clearCounts();
    pulseStart();
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd2; regWdata = 32'hC00;
    @(negedge clk);
    regAddr = 3'd0; regWdata = 32'h0;
    @(negedge clk);
    regWe = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (6) @(negedge clk);
    check(errFlag == 1'b1, "R9 error flag after discarded writes", errFlag, 1);
    check(writesSeen == 4, "R10 start while busy ignored", writesSeen, 4);
    check(irqSeen == 1 && !busy, "R10 no second run", irqSeen, 1);
    compareMem("R9 first run unaffected");
    // rerun without reprogramming: old destination and mode still hold
    fillMem(22);
    modelCopy(32'h100, 32'h800, 16, 4, 4);
    clearCounts();
    pulseStart();
    check(errFlag == 1'b0, "R9 error flag cleared by start", errFlag, 0);
    waitIdle();
    compareMem("R9 registers kept old values");

    check(irqWide == 0, "R11 pulse width one cycle", irqWide, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule